// File: doc/BRIEF.md
# Calibration Trigger and Sequencer

This block decides when a converter's internal calibration runs. After a power-on reset it waits for a settling interval and then starts one automatic calibration. A select pin chooses a short or a long interval, and the interval only advances while the power-down pin is low. Later calibrations are started from a command pin. The command counts only when the pin stays low for a minimum number of clocks and then stays high for a minimum number of clocks.

The calibration itself is modelled as a fixed number of busy clocks. A single-cycle done strobe marks a run that completes. Power-down blocks a run from starting, and it aborts a run that is already in progress without a done strobe. Command activity is ignored while a run is busy. All inputs are treated as synchronous to `clk`. The asynchronous reset is released to the logic through a two-stage synchronizer. The parameters need LOW_MIN >= 1, HIGH_MIN >= 2, CAL_LEN >= 2 and 2 <= DLY_SHORT <= DLY_LONG.

Top module: `cal_sequencer`

## Requirements
- R1: While rst_n is low, cal_busy_o and cal_done_o are 0. The logic ignores all inputs on the first two rising edges after rst_n goes high; the third edge is the first active edge.
- R2: With the command pin low at power-up and power-down low, cal_busy_o rises on edge DLY_SHORT+2 after reset release when dly_sel_i is 0, and on edge DLY_LONG+2 when dly_sel_i is 1.
- R3: Active edges that sample pwr_dn_i high do not advance the power-up interval, so each such edge delays the automatic start by one edge.
- R4: If cal_cmd_i is 1 on the first active edge, no automatic calibration runs.
- R5: A command is valid after at least LOW_MIN consecutive edges that sample cal_cmd_i at 0, followed by HIGH_MIN consecutive edges that sample it at 1. cal_busy_o rises on the edge that samples the HIGH_MIN-th high.
- R6: A low phase shorter than LOW_MIN is discarded when the pin goes high. A high phase shorter than HIGH_MIN is discarded when the pin goes low, and that low sample counts as the first sample of a new low phase.
- R7: cal_busy_o stays high for exactly CAL_LEN cycles. cal_done_o is then high for exactly the one cycle after cal_busy_o falls.
- R8: Command pin activity during cal_busy_o is ignored, and a low phase is counted only from edges where the block is not busy.
- R9: No calibration starts on an edge that samples pwr_dn_i high, and command qualification restarts after power-down.
- R10: An edge that samples pwr_dn_i high while busy drops cal_busy_o, and no cal_done_o follows.
- R11: The automatic calibration runs at most once per power-on. A command calibration that starts before the interval ends cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cal_cmd_i | input | 1 | Calibration command pin |
| dly_sel_i | input | 1 | Power-up interval select: 0 short, 1 long |
| pwr_dn_i | input | 1 | Power-down, active high |
| cal_busy_o | output | 1 | High while a calibration runs |
| cal_done_o | output | 1 | One-cycle strobe when a calibration completes |

## Verification
The hardest situations to reach are command phases that end exactly at, or one clock short of, the minimum lengths, and power-down arriving partway through a run or during the power-up interval. Directed sequences hit each of these boundaries edge by edge. Seeded random runs then toggle the command pin with run lengths of 1 to 6 clocks around the minimum of 3, and add random power-down bursts. A cycle-level reference model built from the requirements checks every clock of the random runs.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    Q_IDLE = 2'd0,
    Q_LOW  = 2'd1,
    Q_HIGH = 2'd2
  } qual_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cmd_qualifier.sv
module cmd_qualifier
  import cal_seq_pkg::*;
#(
  parameter int LOW_MIN  = 3,
  parameter int HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic cmd_i,
  output logic fire_o
);

  localparam int CMAX = imax(LOW_MIN, HIGH_MIN);
  localparam int CW   = $clog2(CMAX + 1);

  qual_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire_o = 1'b0;
    if (clear_i) begin
      st_d  = Q_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        Q_IDLE: begin
          if (!cmd_i) begin
            st_d  = Q_LOW;
            cnt_d = CW'(1);
          end
        end
        Q_LOW: begin
          if (!cmd_i) begin
            if (cnt_q < CW'(LOW_MIN)) cnt_d = cnt_q + 1'b1;
          end else if (cnt_q >= CW'(LOW_MIN)) begin
            st_d  = Q_HIGH;
            cnt_d = CW'(1);
          end else begin
            st_d  = Q_IDLE;
            cnt_d = '0;
          end
        end
        Q_HIGH: begin
          if (cmd_i) begin
            if (cnt_q == CW'(HIGH_MIN - 1)) begin
              fire_o = 1'b1;
              st_d   = Q_IDLE;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            // the sample that cut the high phase opens a fresh low phase
            st_d  = Q_LOW;
            cnt_d = CW'(1);
          end
        end
        default: begin
          st_d  = Q_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= Q_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/powerup_timer.sv
module powerup_timer
  import cal_seq_pkg::*;
#(
  parameter int DLY_SHORT = 20,
  parameter int DLY_LONG  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic pd_i,
  input  logic cmd_i,
  input  logic start_i,
  output logic fire_o
);

  localparam int DMAX = imax(DLY_SHORT, DLY_LONG);
  localparam int DW   = $clog2(DMAX + 1);

  logic          first_q, arm_q, arm_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] tgt_m1;
  logic          cnt_en;
  logic          inhibit;

  assign tgt_m1  = sel_i ? DW'(DLY_LONG - 1) : DW'(DLY_SHORT - 1);
  assign inhibit = first_q && cmd_i;
  assign cnt_en  = arm_q && !pd_i;

  always_comb begin
    fire_o = cnt_en && (cnt_q >= tgt_m1) && !inhibit;
    arm_d  = arm_q;
    if (start_i || inhibit) arm_d = 1'b0;
    cnt_d  = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      arm_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      first_q <= 1'b0;
      arm_q   <= arm_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/cal_engine.sv
module cal_engine #(
  parameter int CAL_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pd_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(CAL_LEN);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign start_o = req_i && !busy_q && !pd_i;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      if (pd_i) begin
        busy_d = 1'b0;
      end else if (cnt_q == CW'(CAL_LEN - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
    end else if (start_o) begin
      busy_d = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int LOW_MIN   = 3,
  parameter int HIGH_MIN  = 3,
  parameter int CAL_LEN   = 12,
  parameter int DLY_SHORT = 20,
  parameter int DLY_LONG  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_cmd_i,
  input  logic dly_sel_i,
  input  logic pwr_dn_i,
  output logic cal_busy_o,
  output logic cal_done_o
);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       cmd_fire;
  logic       auto_fire;
  logic       cal_start;
  logic       qual_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign qual_clear = cal_busy_o || pwr_dn_i;

  cmd_qualifier #(
    .LOW_MIN (LOW_MIN),
    .HIGH_MIN(HIGH_MIN)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear_i(qual_clear),
    .cmd_i  (cal_cmd_i),
    .fire_o (cmd_fire)
  );

  powerup_timer #(
    .DLY_SHORT(DLY_SHORT),
    .DLY_LONG (DLY_LONG)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sel_i  (dly_sel_i),
    .pd_i   (pwr_dn_i),
    .cmd_i  (cal_cmd_i),
    .start_i(cal_start),
    .fire_o (auto_fire)
  );

  cal_engine #(
    .CAL_LEN(CAL_LEN)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (cmd_fire || auto_fire),
    .pd_i   (pwr_dn_i),
    .start_o(cal_start),
    .busy_o (cal_busy_o),
    .done_o (cal_done_o)
  );

endmodule

// File: rtl/cal_seq_checks.sv
module cal_seq_checks #(
  parameter int CAL_LEN = 12
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_dn_i,
  input logic cal_busy_o,
  input logic cal_done_o,
  input logic cmd_fire,
  input logic auto_fire
);

  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 0;
    else if (cal_busy_o) run_q <= run_q + 1;
    else                 run_q <= 0;
  end

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> (run_q == CAL_LEN));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> ($past(cal_busy_o) && !cal_busy_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && pwr_dn_i) |=> (!cal_busy_o && !cal_done_o));

  p_start_no_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy_o) |-> !$past(pwr_dn_i));

  p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy_o) |-> $past(cmd_fire || auto_fire));

  p_busy_ignores_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |-> !cmd_fire);

endmodule

bind cal_sequencer cal_seq_checks #(.CAL_LEN(CAL_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_dn_i  (pwr_dn_i),
  .cal_busy_o(cal_busy_o),
  .cal_done_o(cal_done_o),
  .cmd_fire  (cmd_fire),
  .auto_fire (auto_fire)
);

// File: tb/cal_sequencer_tb_top.sv
`timescale 1ns/1ps
module cal_sequencer_tb_top;

  localparam int LMIN = 3;
  localparam int HMIN = 3;
  localparam int CALN = 12;
  localparam int DS   = 20;
  localparam int DL   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_cmd = 1'b0;
  logic dly_sel = 1'b0;
  logic pwr_dn = 1'b0;
  logic cal_busy_o, cal_done_o;

  int n_chk = 0;
  int n_bad = 0;
  int edge_ctr = 0;
  int done_seen = 0;
  int busy_run = 0;
  int last_len = 0;

  // reference model state
  int rel = 0;
  bit m_busy = 0, m_done = 0, m_arm = 1, m_first = 1;
  int m_bc = 0, m_ph = 0, m_qc = 0, m_el = 0;

  always #2.5 clk = ~clk;

  cal_sequencer #(
    .LOW_MIN(LMIN), .HIGH_MIN(HMIN), .CAL_LEN(CALN),
    .DLY_SHORT(DS), .DLY_LONG(DL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_cmd_i(cal_cmd), .dly_sel_i(dly_sel),
    .pwr_dn_i(pwr_dn), .cal_busy_o(cal_busy_o), .cal_done_o(cal_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit pd, c, clr, cf, af, st;
    int tgt;
    pd  = pwr_dn;
    c   = cal_cmd;
    tgt = dly_sel ? DL : DS;
    clr = m_busy || pd;
    cf  = !clr && (m_ph == 2) && c && (m_qc == HMIN - 1);
    af  = m_arm && !pd && (m_el >= tgt - 1) && !(m_first && c);
    st  = !m_busy && !pd && (cf || af);
    m_done = 0;
    if (m_busy) begin
      if (pd) m_busy = 0;
      else if (m_bc == CALN - 1) begin m_busy = 0; m_done = 1; end
      else m_bc++;
    end else if (st) begin
      m_busy = 1; m_bc = 0;
    end
    if (st || (m_first && c)) m_arm = 0;
    else if (m_arm && !pd) m_el++;
    m_first = 0;
    if (clr || cf) begin m_ph = 0; m_qc = 0; end
    else begin
      case (m_ph)
        0: if (!c) begin m_ph = 1; m_qc = 1; end
        1: if (!c) begin if (m_qc < LMIN) m_qc++; end
           else if (m_qc >= LMIN) begin m_ph = 2; m_qc = 1; end
           else begin m_ph = 0; m_qc = 0; end
        default: if (c) m_qc++; else begin m_ph = 1; m_qc = 1; end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_busy = 0; m_done = 0; m_bc = 0; m_ph = 0; m_qc = 0;
      m_arm = 1; m_el = 0; m_first = 1; edge_ctr = 0;
    end else begin
      if (rel >= 2) model_step();
      rel++;
      edge_ctr++;
    end
  end

  always @(negedge clk) begin
    chk(cal_busy_o === m_busy, "R7 busy vs model", int'(cal_busy_o), int'(m_busy));
    chk(cal_done_o === m_done, "R7 done vs model", int'(cal_done_o), int'(m_done));
    if (cal_busy_o) busy_run++;
    if (cal_done_o) begin done_seen++; last_len = busy_run; end
    if (!cal_busy_o) busy_run = 0;
  end

  task automatic por(input bit sel, input bit c, input bit pd);
    @(negedge clk);
    rst_n = 1'b0; dly_sel = sel; cal_cmd = c; pwr_dn = pd;
    repeat (3) @(negedge clk);
    chk(!cal_busy_o && !cal_done_o, "R1 idle in reset", int'(cal_busy_o), 0);
    rst_n = 1'b1;
    done_seen = 0;
  endtask

  task automatic until_busy(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cal_busy_o) begin at = edge_ctr; break; end
    end
  endtask

  task automatic cmd_pattern(input int lows, input int highs);
    cal_cmd = 1'b0;
    repeat (lows) @(negedge clk);
    cal_cmd = 1'b1;
    repeat (highs) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int at;
    void'($urandom(32'd4711));

    // R1 / R2: short interval
    por(1'b0, 1'b0, 1'b0);
    chk(!cal_busy_o, "R1 inputs ignored right after release", int'(cal_busy_o), 0);
    until_busy(200, at);
    chk(at == DS + 2, "R2 short interval start edge", at, DS + 2);
    idle(CALN + 2);
    chk(last_len == CALN, "R7 busy length", last_len, CALN);
    idle(150);
    chk(done_seen == 1, "R11 automatic run only once", done_seen, 1);

    // R2: long interval
    por(1'b1, 1'b0, 1'b0);
    until_busy(200, at);
    chk(at == DL + 2, "R2 long interval start edge", at, DL + 2);
    idle(CALN + 5);

    // R3: power-down held through power-up freezes interval
    por(1'b0, 1'b0, 1'b1);
    idle(10);
    pwr_dn = 1'b0;
    until_busy(200, at);
    chk(at == DS + 10, "R3 frozen interval start edge", at, DS + 10);
    idle(CALN + 5);

    // R4: command high at power-up
    por(1'b0, 1'b1, 1'b0);
    idle(150);
    chk(done_seen == 0 && !cal_busy_o, "R4 no automatic run", done_seen, 0);

    // R5: exact minimum command
    cal_cmd = 1'b0;
    idle(LMIN);
    cal_cmd = 1'b1;
    idle(HMIN - 1);
    chk(!cal_busy_o, "R5 not started before last high", int'(cal_busy_o), 0);
    idle(1);
    chk(cal_busy_o, "R5 started on last high", int'(cal_busy_o), 1);

    // R8: full pattern while busy is ignored
    cmd_pattern(LMIN, HMIN);
    idle(CALN + 30);
    chk(done_seen == 1, "R8 command during busy ignored", done_seen, 1);

    // R6: short low discarded
    cmd_pattern(LMIN - 1, 10);
    chk(!cal_busy_o && done_seen == 1, "R6 short low discarded", int'(cal_busy_o), 0);

    // R6: short high discarded, next low counts from its first sample
    cmd_pattern(LMIN, HMIN - 1);
    chk(!cal_busy_o, "R6 short high discarded", int'(cal_busy_o), 0);
    cal_cmd = 1'b0;
    idle(LMIN);
    cal_cmd = 1'b1;
    idle(HMIN);
    chk(cal_busy_o, "R6 low after short high counted", int'(cal_busy_o), 1);
    idle(CALN + 5);

    // R9: power-down blocks a command
    pwr_dn = 1'b1;
    cmd_pattern(LMIN + 2, HMIN + 4);
    chk(!cal_busy_o, "R9 no start in power-down", int'(cal_busy_o), 0);
    pwr_dn = 1'b0;
    idle(20);
    chk(!cal_busy_o, "R9 qualifier restarted", int'(cal_busy_o), 0);

    // R10: abort
    done_seen = 0;
    cmd_pattern(LMIN, HMIN);
    idle(4);
    pwr_dn = 1'b1;
    idle(1);
    chk(!cal_busy_o, "R10 busy dropped on power-down", int'(cal_busy_o), 0);
    idle(5);
    pwr_dn = 1'b0;
    idle(30);
    chk(done_seen == 0, "R10 no done after abort", done_seen, 0);

    // R11: early command cancels the automatic run
    por(1'b0, 1'b0, 1'b0);
    idle(2);
    cmd_pattern(LMIN, HMIN + 2);
    idle(150);
    chk(done_seen == 1, "R11 command cancels automatic run", done_seen, 1);

    // random runs checked cycle by cycle against the model
    for (int r = 0; r < 20; r++) begin
      int cmd_left, pd_left;
      por(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      cmd_left = $urandom_range(1, 6);
      pd_left  = $urandom_range(1, 20);
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        cmd_left--;
        if (cmd_left == 0) begin
          cal_cmd  = ~cal_cmd;
          cmd_left = $urandom_range(1, 6);
        end
        pd_left--;
        if (pd_left == 0) begin
          if (pwr_dn) begin pwr_dn = 1'b0; pd_left = $urandom_range(20, 120); end
          else        begin pwr_dn = 1'b1; pd_left = $urandom_range(1, 8); end
        end
      end
      pwr_dn = 1'b0;
    end

    idle(5);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule